// File: doc/BRIEF.md
# Cascadable Programmable Interrupt Controller

A controller that gathers 32 interrupt request lines, conditions each one according to its own sense and polarity settings, and latches requests into a pending register. Software uses a small word-addressed register port to configure and service the block. Each pending source is gated by an enable bit. It is then steered to either a normal or a critical interrupt output.

All registers number their bits with the most significant bit first, so that input 0 is bit 31. Pending bits are cleared by writing ones. A level-sensitive source that is still asserted after software clears it sets its bit again. This is what allows several controllers to be chained: a child's normal output drives a level-sensitive input of a parent. Software clears the child's bit first, then the parent's cascade bit, and a request that has not been serviced returns.

Raw inputs pass through a two-flop synchroniser. Sense detection follows the synchroniser. Both interrupt outputs are registered.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Input n maps to bit (31 - n) of every register, so input 0 is the most significant bit.
- R2: A write to the pending register (address 0) clears each bit written as 1 and leaves bits written as 0 unchanged. A set condition in the same cycle wins over the clear.
- R3: Address 5 reads pending AND enable. Writes to address 5 change no register.
- R4: With trigger bit 0 (level), a bit is set while the input is active. It sets again after a clear if the input is still active.
- R5: With trigger bit 1 (edge), a bit is set on the selected edge. It stays set after the input returns to idle, until cleared. A steady active level after the clear does not set it again.
- R6: Polarity bit 1 selects active-high level or rising edge. Polarity bit 0 selects active-low level or falling edge.
- R7: Both outputs are registered. irq_norm_o is the OR of (pending & enable & ~critical). irq_crit_o is the OR of (pending & enable & critical).
- R8: After reset, the polarity register reads all ones and every other register reads zero, and both outputs are low.
- R9: Register addresses: 0 pending, 1 enable, 2 critical, 3 polarity, 4 trigger, 5 masked pending. Addresses 1 to 4 read back the value written. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Raw interrupt requests; irq_i[n] is input n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | N_SRC | Write data |
| rdata_o | output | N_SRC | Read data for addr_i (combinational) |
| irq_norm_o | output | 1 | Normal interrupt output |
| irq_crit_o | output | 1 | Critical interrupt output |

## Verification
The assertions assume that the register strobe and address are stable at each rising edge. They also assume the raw inputs may be asynchronous, so the assertions look only at signals after the synchroniser and never at irq_i directly.

The stimulus changes irq_i and the register port only on falling edges. It waits several cycles after any change to the inputs, polarity or trigger before clearing the pending register, so the synchroniser and edge history settle. Assertions on set-over-clear ordering and on output registration then hold for every write the bench issues.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [2:0] {
    RA_PEND   = 3'd0,
    RA_ENABLE = 3'd1,
    RA_CRIT   = 3'd2,
    RA_POL    = 3'd3,
    RA_TRIG   = 3'd4,
    RA_MASKED = 3'd5
  } reg_addr_e;
  localparam int unsigned ADDR_W = 3;
endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/cic_sense.sv
module cic_sense #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] trig_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] act, act_q;
  // active-high view after polarity inversion
  assign act = ~(sync_i ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign set_o[i] = trig_i[i] ? (act[i] & ~act_q[i]) : act[i];
  end
endmodule

// File: rtl/cic_out.sv
module cic_out #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] masked_i,
  input  logic [W-1:0] crit_i,
  output logic         norm_o,
  output logic         crit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_o <= 1'b0;
      crit_o <= 1'b0;
    end else begin
      norm_o <= |(masked_i & ~crit_i);
      crit_o <= |(masked_i & crit_i);
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_norm_o,
  output logic              irq_crit_o
);
  localparam int unsigned MSB = N_SRC - 1;

  logic [N_SRC-1:0] src_msb, src_sync, set_v, clr_v;
  logic [N_SRC-1:0] pend_q, en_q, crit_q, pol_q, trig_q, masked;

  // input n lands on register bit MSB-n
  for (genvar n = 0; n < N_SRC; n++) begin : g_map
    assign src_msb[MSB-n] = irq_i[n];
  end

  cic_sync #(.W(N_SRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_msb), .q_o(src_sync)
  );

  cic_sense #(.W(N_SRC)) u_sense (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(src_sync),
    .pol_i(pol_q), .trig_i(trig_q), .set_o(set_v)
  );

  assign clr_v  = (wr_en_i && addr_i == RA_PEND) ? wdata_i : '0;
  assign masked = pend_q & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '1;
      trig_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | set_v;  // set wins
      if (wr_en_i) begin
        case (addr_i)
          RA_ENABLE: en_q   <= wdata_i;
          RA_CRIT:   crit_q <= wdata_i;
          RA_POL:    pol_q  <= wdata_i;
          RA_TRIG:   trig_q <= wdata_i;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      RA_PEND:   rdata_o = pend_q;
      RA_ENABLE: rdata_o = en_q;
      RA_CRIT:   rdata_o = crit_q;
      RA_POL:    rdata_o = pol_q;
      RA_TRIG:   rdata_o = trig_q;
      RA_MASKED: rdata_o = masked;
      default:   rdata_o = '0;
    endcase
  end

  cic_out #(.W(N_SRC)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .masked_i(masked), .crit_i(crit_q),
    .norm_o(irq_norm_o), .crit_o(irq_crit_o)
  );
endmodule

// File: rtl/cic_chk.sv
module cic_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [2:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] pend_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] crit_q,
  input logic [W-1:0] set_v,
  input logic         irq_norm_o,
  input logic         irq_crit_o
);
  // R2
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0) |=> ((pend_q & $past(wdata_i & ~set_v)) == '0));

  // R2
  no_spurious_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 3'd0) |=> (($past(pend_q) & ~pend_q) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v != '0) |=> ((pend_q & $past(set_v)) == $past(set_v)));

  // R3
  masked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd5) |-> (rdata_o == (pend_q & en_q)));

  // R7
  norm_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_norm_o == $past(|(pend_q & en_q & ~crit_q))));

  // R7
  crit_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_crit_o == $past(|(pend_q & en_q & crit_q))));
endmodule

bind cascade_irq_ctrl cic_chk #(.W(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pend_q(pend_q), .en_q(en_q),
  .crit_q(crit_q), .set_v(set_v), .irq_norm_o(irq_norm_o),
  .irq_crit_o(irq_crit_o)
);

// File: tb/tb_cascade_irq_ctrl.sv
module tb_cascade_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_norm_o, irq_crit_o;

  int checks = 0, failures = 0;
  bit done = 0;

  cascade_irq_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {addr, write data, expected readback}
  localparam logic [66:0] VEC [6] = '{
    {3'd1, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {3'd2, 32'h0000_FFFF, 32'h0000_FFFF},
    {3'd4, 32'h1234_5678, 32'h1234_5678},
    {3'd3, 32'hFFFF_0000, 32'hFFFF_0000},
    {3'd6, 32'hDEAD_BEEF, 32'h0000_0000},
    {3'd7, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  function automatic logic [31:0] bm(int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic clks(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic settle_clear();
    clks(5);
    wr(3'd0, 32'hFFFF_FFFF);
    clks(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    clks(3);
    rst_ni = 1'b1;
    clks(1);

    // R8 reset values
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], r);
      chk("R8", r, (a == 3) ? 32'hFFFF_FFFF : 32'h0);
    end
    chk("R8 outputs", {30'd0, irq_norm_o, irq_crit_o}, 32'h0);

    // R9 table walk
    foreach (VEC[i]) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], r);
      chk("R9", r, VEC[i][31:0]);
    end
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0);
    settle_clear();

    // R1 R4 level active-high on input 0
    irq_i[0] = 1'b1;
    clks(5);
    rd(3'd0, r);
    chk("R1", r, 32'h8000_0000);
    chk("R7 norm", {31'd0, irq_norm_o}, 32'd1);
    chk("R7 crit low", {31'd0, irq_crit_o}, 32'd0);
    wr(3'd0, 32'h8000_0000);
    clks(2);
    rd(3'd0, r);
    chk("R4 relatch", r, 32'h8000_0000);
    irq_i[0] = 1'b0;
    clks(5);
    rd(3'd0, r);
    chk("R4 held after idle", r, 32'h8000_0000);
    wr(3'd0, 32'h8000_0000);
    clks(2);
    rd(3'd0, r);
    chk("R2 clear", r, 32'h0);
    chk("R7 norm low", {31'd0, irq_norm_o}, 32'd0);

    // R2 zero bits leave others
    irq_i[3] = 1'b1; irq_i[5] = 1'b1;
    clks(5);
    irq_i[3] = 1'b0; irq_i[5] = 1'b0;
    clks(5);
    wr(3'd0, bm(3));
    rd(3'd0, r);
    chk("R2 partial", r, bm(5));
    wr(3'd0, 32'hFFFF_FFFF);

    // R5 rising edge on input 7
    wr(3'd4, bm(7));
    settle_clear();
    irq_i[7] = 1'b1;
    clks(3);
    irq_i[7] = 1'b0;
    clks(5);
    rd(3'd0, r);
    chk("R5 edge held", r, bm(7));
    wr(3'd0, bm(7));
    irq_i[7] = 1'b1;
    clks(5);
    wr(3'd0, bm(7));
    clks(5);
    rd(3'd0, r);
    chk("R5 no relatch", r, 32'h0);
    irq_i[7] = 1'b0;
    wr(3'd4, 32'h0);
    settle_clear();

    // R6 active-low level on input 10
    irq_i[10] = 1'b1;
    wr(3'd3, ~bm(10));
    settle_clear();
    rd(3'd0, r);
    chk("R6 high inactive", r, 32'h0);
    irq_i[10] = 1'b0;
    clks(5);
    rd(3'd0, r);
    chk("R6 low active", r, bm(10));

    // R6 falling edge on input 12
    irq_i[12] = 1'b1;
    wr(3'd3, ~(bm(10) | bm(12)));
    wr(3'd4, bm(12));
    irq_i[10] = 1'b1;
    settle_clear();
    irq_i[12] = 1'b0;
    clks(5);
    rd(3'd0, r);
    chk("R6 falling", r, bm(12));
    irq_i[12] = 1'b1;
    wr(3'd3, 32'hFFFF_FFFF);
    irq_i[10] = 1'b0; irq_i[12] = 1'b0;
    wr(3'd4, 32'h0);
    settle_clear();

    // R7 critical steering on input 2
    wr(3'd2, bm(2));
    irq_i[2] = 1'b1;
    clks(6);
    chk("R7 crit", {30'd0, irq_norm_o, irq_crit_o}, 32'd1);

    // R3 masking and read-only masked view
    wr(3'd1, 32'h0);
    clks(2);
    rd(3'd5, r);
    chk("R3 masked", r, 32'h0);
    chk("R3 outputs", {30'd0, irq_norm_o, irq_crit_o}, 32'd0);
    rd(3'd0, r);
    chk("R3 pend kept", r, bm(2));
    wr(3'd1, bm(2) | bm(9));
    wr(3'd5, 32'h0);
    rd(3'd5, r);
    chk("R3 masked value", r, bm(2));
    rd(3'd1, r);
    chk("R3 write ignored", r, bm(2) | bm(9));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule